// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block decides when a small 8-bit controller core may enter an interrupt handler and then performs the entry on its own. It keeps a bank of pending hardware sources, a latched reset request and the global interrupt-enable flag. When entry is allowed it picks a winner and pushes the return word address onto a byte-wide stack, one byte per clock, through a memory write port. It then hands the core a new program counter. The core is told to hold off by a skip-pending input, which marks that the next instruction is to be skipped and must not be split from the one before it.

The winner is the reset request if one is latched. Otherwise it is the lowest-numbered pending source. Its vector number, 0 for reset and source index plus 1 otherwise, is scaled by a slot size of one or two words to give the target address. Two strap inputs give the slot size and the width of the return address (1, 2 or 3 bytes). They are sampled when an entry is accepted. Instruction fetch, execution and the stack memory sit outside the block.

Top module: `irq_entry_seq`

## Requirements
- R1: No entry, reset or hardware, is accepted in a cycle where `skip_i` is 1. A request held pending through such cycles is accepted once `skip_i` returns to 0.
- R2: An entry is accepted only while `ie_o` is 1. A latched reset request (pulse on `reset_req_i`) takes precedence over pending hardware sources. It uses vector 0 and target address 0, and leaves the hardware pending bits untouched.
- R3: For hardware entry the lowest set index of `pend_o` wins, and its vector number is index+1. One cycle after acceptance `taken_o` pulses for exactly one cycle with that number on `taken_vec_o`.
- R4: The target address is vector×2 when `long_vec_i` is 1 and vector×1 when it is 0. It appears on `new_pc_o` while `pc_load_o` is high, for the single cycle after the last stack write.
- R5: The return address `cur_pc_i`, sampled at acceptance, is written one byte per clock with `mem_we_o` high, low byte first. `pc_bytes_i` = 3 writes 3 bytes, 2 writes 2 bytes, and 0 or 1 writes 1 byte.
- R6: Each byte is written at address `sp_o`, and `sp_o` then drops by one, so after n bytes it is its start value minus n. `sp_wr_i` loads `sp_o` only when the block is idle and no entry is accepted in that cycle.
- R7: Acceptance clears `ie_o`. Writes through `ie_wr_i` are ignored while `busy_o` is 1.
- R8: Acceptance clears the winning pending bit. A `pend_set_i` bit raised in the acceptance cycle for the same source keeps it pending. Bits set while busy stay pending. `hw_req_o` is 1 exactly when any bit of `pend_o` is set.
- R9: `busy_o` is high from the cycle after acceptance through the `pc_load_o` cycle, which is n+1 cycles for n pushed bytes. No further entry is accepted in that time.
- R10: After synchronous reset `busy_o`, `ie_o`, `hw_req_o`, `mem_we_o`, `pc_load_o` and `taken_o` are 0, `pend_o` is 0 and `sp_o` equals `SP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req_i | input | 1 | Pulse that latches a reset-entry request |
| pend_set_i | input | NSRC | Per-source pulses that set pending bits |
| ie_wr_i | input | 1 | Write strobe for the interrupt-enable flag |
| ie_wdata_i | input | 1 | Value written to the enable flag |
| skip_i | input | 1 | Skip pending; holds off entry |
| long_vec_i | input | 1 | Strap: two-word vector slots |
| pc_bytes_i | input | 2 | Strap: return bytes (3, 2, else 1) |
| cur_pc_i | input | PC_W | Return word address of the core |
| sp_wr_i | input | 1 | Stack pointer load strobe |
| sp_wdata_i | input | SP_W | Stack pointer load value |
| mem_we_o | output | 1 | Stack byte write enable |
| mem_addr_o | output | SP_W | Stack byte write address |
| mem_wdata_o | output | 8 | Stack byte write data |
| sp_o | output | SP_W | Current stack pointer |
| pc_load_o | output | 1 | Load strobe for the new program counter |
| new_pc_o | output | PC_W | New program counter |
| ie_o | output | 1 | Global interrupt-enable flag |
| pend_o | output | NSRC | Pending source bits |
| hw_req_o | output | 1 | Any hardware source pending |
| busy_o | output | 1 | Entry sequence in progress |
| taken_o | output | 1 | One-cycle pulse after acceptance |
| taken_vec_o | output | 8 | Vector number of the accepted entry |

## Verification
Two things can land in one cycle. The first is clearing a serviced pending bit at acceptance while the same source raises a new request. The bench drives the set pulse in exactly the acceptance cycle, the first cycle in which the enable flag reads 1, and expects the bit to stay pending and to be taken again later. The second is an enable write or stack-pointer load arriving while the push is in progress. The bench expects the write to be ignored: the flag stays 0, the final pointer equals the start minus the bytes pushed, and only one entry is reported. A reset request pending together with hardware sources checks precedence, and a full sweep over every source and every strap setting checks each byte, address and target against arithmetic.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int VEC_W = 8;
    localparam int RET_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [RET_W-1:0] ret;
        logic [VEC_W-1:0] vec;
        logic [1:0]       last_k;
        logic             long_slot;
    } entry_req_t;

    // index of the final byte to push, derived from the width strap
    function automatic logic [1:0] last_byte_index(input logic [1:0] strap);
        logic [1:0] r;
        case (strap)
            2'd3:    r = 2'd2;
            2'd2:    r = 2'd1;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] ret_byte(input logic [RET_W-1:0] ret,
                                            input logic [1:0] k);
        logic [7:0] b;
        case (k)
            2'd0:    b = ret[7:0];
            2'd1:    b = ret[15:8];
            default: b = ret[23:16];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC  = 64,
    parameter int IDX_W = 6
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [NSRC:0]   below;
    logic [NSRC-1:0] first_oh;

    assign below[0] = 1'b0;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_chain
            assign first_oh[i]  = pend_i[i] & ~below[i];
            assign below[i + 1] = below[i] | pend_i[i];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (first_oh[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign any_o = below[NSRC];

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int NSRC  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  set_i,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    output logic [NSRC-1:0]  pend_o
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en_i) clr_mask[clr_idx_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_mask) | set_i;
    end

    assign pend_o = pend_q;

    // R8: a serviced bit is gone next cycle unless re-raised
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_en_i && ((set_i & clr_mask) == '0)) |=> ((pend_o & $past(clr_mask)) == '0));

    // R8: a raised bit is always held
    p_set_r8: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/irq_push_fsm.sv
module irq_push_fsm
    import irq_entry_pkg::*;
#(
    parameter int             PC_W    = 22,
    parameter int             SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = 16'h08FF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  entry_req_t       req_i,
    input  logic             sp_wr_i,
    input  logic [SP_W-1:0]  sp_wdata_i,
    output logic             busy_o,
    output logic             mem_we_o,
    output logic [SP_W-1:0]  mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  new_pc_o,
    output logic             taken_o,
    output logic [VEC_W-1:0] taken_vec_o
);

    seq_state_e      state_q;
    entry_req_t      req_q;
    logic [1:0]      k_q;
    logic [SP_W-1:0] sp_q;
    logic            taken_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            k_q     <= 2'd0;
            sp_q    <= SP_INIT;
            taken_q <= 1'b0;
        end else begin
            taken_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q   <= req_i;
                        k_q     <= 2'd0;
                        taken_q <= 1'b1;
                        state_q <= ST_PUSH;
                    end else if (sp_wr_i) begin
                        sp_q <= sp_wdata_i;
                    end
                end
                ST_PUSH: begin
                    sp_q <= sp_q - 1'b1;
                    k_q  <= k_q + 2'd1;
                    if (k_q == req_q.last_k) state_q <= ST_LOAD;
                end
                ST_LOAD: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign mem_we_o    = (state_q == ST_PUSH);
    assign mem_addr_o  = sp_q;
    assign mem_wdata_o = ret_byte(req_q.ret, k_q);
    assign sp_o        = sp_q;
    assign pc_load_o   = (state_q == ST_LOAD);
    assign new_pc_o    = req_q.long_slot ? PC_W'({req_q.vec, 1'b0}) : PC_W'(req_q.vec);
    assign taken_o     = taken_q;
    assign taken_vec_o = req_q.vec;

    // R6: every pushed byte moves the pointer down by one
    p_sp_step_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> (sp_o == $past(sp_o) - 1'b1));

    // R4: the load cycle ends the sequence
    p_load_exit_r4: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !busy_o);

    // R9: the taken pulse coincides with the first byte write
    p_taken_first_r9: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (mem_we_o && (k_q == 2'd0)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int              NSRC    = 64,
    parameter int              PC_W    = 22,
    parameter int              SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = 16'h08FF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_req_i,
    input  logic [NSRC-1:0]  pend_set_i,
    input  logic             ie_wr_i,
    input  logic             ie_wdata_i,
    input  logic             skip_i,
    input  logic             long_vec_i,
    input  logic [1:0]       pc_bytes_i,
    input  logic [PC_W-1:0]  cur_pc_i,
    input  logic             sp_wr_i,
    input  logic [SP_W-1:0]  sp_wdata_i,
    output logic             mem_we_o,
    output logic [SP_W-1:0]  mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  new_pc_o,
    output logic             ie_o,
    output logic [NSRC-1:0]  pend_o,
    output logic             hw_req_o,
    output logic             busy_o,
    output logic             taken_o,
    output logic [VEC_W-1:0] taken_vec_o
);

    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic             ie_q;
    logic             rst_pend_q;
    logic             any_hw;
    logic [IDX_W-1:0] win_idx;
    logic             accept;
    logic             clr_en;
    entry_req_t       req;

    irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) pick_i (
        .pend_i (pend_o),
        .any_o  (any_hw),
        .idx_o  (win_idx)
    );

    irq_pend_reg #(.NSRC(NSRC), .IDX_W(IDX_W)) pend_i (
        .clk       (clk),
        .rst       (rst),
        .set_i     (pend_set_i),
        .clr_en_i  (clr_en),
        .clr_idx_i (win_idx),
        .pend_o    (pend_o)
    );

    assign accept = !busy_o && !skip_i && ie_q && (rst_pend_q || any_hw);
    assign clr_en = accept && !rst_pend_q;

    always_comb begin
        req.ret       = RET_W'(cur_pc_i);
        req.vec       = rst_pend_q ? '0 : (VEC_W'(win_idx) + VEC_W'(1));
        req.last_k    = last_byte_index(pc_bytes_i);
        req.long_slot = long_vec_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q       <= 1'b0;
            rst_pend_q <= 1'b0;
        end else begin
            rst_pend_q <= (rst_pend_q && !accept) || reset_req_i;
            if (accept)                  ie_q <= 1'b0;
            else if (ie_wr_i && !busy_o) ie_q <= ie_wdata_i;
        end
    end

    irq_push_fsm #(.PC_W(PC_W), .SP_W(SP_W), .SP_INIT(SP_INIT)) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (accept),
        .req_i       (req),
        .sp_wr_i     (sp_wr_i),
        .sp_wdata_i  (sp_wdata_i),
        .busy_o      (busy_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .sp_o        (sp_o),
        .pc_load_o   (pc_load_o),
        .new_pc_o    (new_pc_o),
        .taken_o     (taken_o),
        .taken_vec_o (taken_vec_o)
    );

    assign ie_o     = ie_q;
    assign hw_req_o = any_hw;

    // R1: a pending skip forbids acceptance
    p_skip_hold_r1: assert property (@(posedge clk) disable iff (rst)
        skip_i |=> !taken_o);

    // R2: no entry without the enable flag
    p_ie_gate_r2: assert property (@(posedge clk) disable iff (rst)
        !ie_o |=> !taken_o);

    // R2: a latched reset request wins with vector 0
    p_reset_first_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && rst_pend_q) |=> (taken_vec_o == '0));

    // R7: enable flag is low once an entry has been reported
    p_ie_clear_r7: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> !ie_o);

    // R9: no second entry while the sequence is running
    p_no_reentry_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !pc_load_o) |=> !taken_o);

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NSRC    = 64;
    localparam int          PC_W    = 22;
    localparam int          SP_W    = 16;
    localparam logic [15:0] SP_INIT = 16'h08FF;

    logic            clk;
    logic            rst;
    logic            reset_req_i;
    logic [NSRC-1:0] pend_set_i;
    logic            ie_wr_i, ie_wdata_i, skip_i, long_vec_i;
    logic [1:0]      pc_bytes_i;
    logic [PC_W-1:0] cur_pc_i;
    logic            sp_wr_i;
    logic [SP_W-1:0] sp_wdata_i;
    logic            mem_we_o;
    logic [SP_W-1:0] mem_addr_o;
    logic [7:0]      mem_wdata_o;
    logic [SP_W-1:0] sp_o;
    logic            pc_load_o;
    logic [PC_W-1:0] new_pc_o;
    logic            ie_o;
    logic [NSRC-1:0] pend_o;
    logic            hw_req_o, busy_o, taken_o;
    logic [7:0]      taken_vec_o;

    irq_entry_seq #(.NSRC(NSRC), .PC_W(PC_W), .SP_W(SP_W), .SP_INIT(SP_INIT)) dut_i (
        .clk(clk), .rst(rst), .reset_req_i(reset_req_i), .pend_set_i(pend_set_i),
        .ie_wr_i(ie_wr_i), .ie_wdata_i(ie_wdata_i), .skip_i(skip_i),
        .long_vec_i(long_vec_i), .pc_bytes_i(pc_bytes_i), .cur_pc_i(cur_pc_i),
        .sp_wr_i(sp_wr_i), .sp_wdata_i(sp_wdata_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .sp_o(sp_o),
        .pc_load_o(pc_load_o), .new_pc_o(new_pc_o), .ie_o(ie_o), .pend_o(pend_o),
        .hw_req_o(hw_req_o), .busy_o(busy_o), .taken_o(taken_o), .taken_vec_o(taken_vec_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;

    int              mon_taken, mon_wr, mon_busy, mon_load;
    logic [7:0]      mon_vec;
    logic [PC_W-1:0] mon_pc;
    logic [15:0]     mon_addr [4];
    logic [7:0]      mon_data [4];

    always @(negedge clk) begin
        if (taken_o) begin
            mon_taken = mon_taken + 1;
            mon_vec   = taken_vec_o;
        end
        if (mem_we_o) begin
            if (mon_wr < 4) begin
                mon_addr[mon_wr] = mem_addr_o;
                mon_data[mon_wr] = mem_wdata_o;
            end
            mon_wr = mon_wr + 1;
        end
        if (busy_o) mon_busy = mon_busy + 1;
        if (pc_load_o) begin
            mon_load = mon_load + 1;
            mon_pc   = new_pc_o;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clr_mon();
        mon_taken = 0; mon_wr = 0; mon_busy = 0; mon_load = 0;
    endtask

    task automatic wait_load();
        int n;
        n = 0;
        while (mon_load == 0 && n < 40) begin
            tick();
            n++;
        end
    endtask

    task automatic set_pend(input logic [NSRC-1:0] bits);
        pend_set_i = bits;
        tick();
        pend_set_i = '0;
    endtask

    task automatic enable_ie();
        ie_wr_i = 1'b1; ie_wdata_i = 1'b1;
        tick();
        ie_wr_i = 1'b0;
    endtask

    task automatic load_sp(input logic [15:0] v);
        sp_wr_i = 1'b1; sp_wdata_i = v;
        tick();
        sp_wr_i = 1'b0;
    endtask

    task automatic check_entry(input int vec, input int nb, input bit lng,
                               input logic [PC_W-1:0] ret, input logic [15:0] sp0);
        logic [23:0] r24;
        r24 = 24'(ret);
        check(mon_taken == 1, "R3 taken pulse count", mon_taken, 1);
        check(mon_vec == 8'(vec), "R3 vector number", mon_vec, vec);
        check(mon_load == 1, "R4 load count", mon_load, 1);
        check(mon_pc == PC_W'(lng ? vec * 2 : vec), "R4 target address", mon_pc, lng ? vec * 2 : vec);
        check(mon_wr == nb, "R5 bytes pushed", mon_wr, nb);
        for (int k = 0; k < nb; k++) begin
            check(mon_addr[k] == sp0 - 16'(k), "R6 write address", mon_addr[k], sp0 - 16'(k));
            check(mon_data[k] == r24[8*k +: 8], "R5 byte data", mon_data[k], r24[8*k +: 8]);
        end
        check(sp_o == sp0 - 16'(nb), "R6 final pointer", sp_o, sp0 - 16'(nb));
        check(ie_o == 1'b0, "R7 enable cleared", ie_o, 0);
        check(mon_busy == nb + 1, "R9 busy length", mon_busy, nb + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [NSRC-1:0] pat, rem;
        int low;
        rst = 1'b1; reset_req_i = 1'b0; pend_set_i = '0; ie_wr_i = 1'b0; ie_wdata_i = 1'b0;
        skip_i = 1'b0; long_vec_i = 1'b0; pc_bytes_i = 2'd0; cur_pc_i = '0;
        sp_wr_i = 1'b0; sp_wdata_i = '0;
        clr_mon();
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10 reset state
        check(busy_o == 0, "R10 busy", busy_o, 0);
        check(ie_o == 0, "R10 enable", ie_o, 0);
        check(pend_o == '0, "R10 pending", pend_o, 0);
        check(hw_req_o == 0, "R10 hw request", hw_req_o, 0);
        check(sp_o == SP_INIT, "R10 pointer", sp_o, SP_INIT);
        check(mem_we_o == 0 && pc_load_o == 0 && taken_o == 0, "R10 strobes", {mem_we_o, pc_load_o, taken_o}, 0);

        // sweep: every source under every strap setting (R3 R4 R5 R6 R8)
        for (int st = 0; st < 4; st++) begin
            for (int lg = 0; lg < 2; lg++) begin
                for (int src = 0; src < NSRC; src++) begin
                    int nb;
                    logic [PC_W-1:0] pc;
                    logic [15:0] sp0;
                    nb  = (st == 3) ? 3 : (st == 2) ? 2 : 1;
                    pc  = PC_W'(src * 4099 + st * 77 + lg * 1031 + 22'h15A5A3);
                    sp0 = 16'h0400 + 16'(src * 4 + st);
                    cur_pc_i = pc; pc_bytes_i = 2'(st); long_vec_i = lg[0];
                    load_sp(sp0);
                    set_pend(NSRC'(1) << src);
                    clr_mon();
                    enable_ie();
                    wait_load();
                    check_entry(src + 1, nb, lg[0], pc, sp0);
                    check(pend_o == '0, "R8 serviced bit cleared", pend_o, 0);
                    check(hw_req_o == 0, "R8 hw request drops", hw_req_o, 0);
                end
            end
        end

        // R3 priority among several pending sources
        long_vec_i = 1'b1; pc_bytes_i = 2'd2;
        for (int p = 0; p < 16; p++) begin
            pat = (NSRC'(1) << ((p * 13 + 5) % 64)) | (NSRC'(1) << ((p * 29 + 40) % 64))
                | (NSRC'(1) << ((p * 7 + 1) % 64));
            set_pend(pat);
            rem = pat;
            while (rem != '0) begin
                low = 0;
                for (int i = NSRC - 1; i >= 0; i--) if (rem[i]) low = i;
                clr_mon();
                enable_ie();
                wait_load();
                check(mon_vec == 8'(low + 1), "R3 lowest index wins", mon_vec, low + 1);
                check(mon_pc == PC_W'((low + 1) * 2), "R4 long slot target", mon_pc, (low + 1) * 2);
                rem = rem & (rem - 1'b1);
                check(pend_o == rem, "R8 remaining pending", pend_o, rem);
                check(hw_req_o == (rem != '0), "R8 hw request", hw_req_o, rem != '0);
            end
        end

        // R1 skip holds off a hardware entry
        long_vec_i = 1'b0; pc_bytes_i = 2'd1;
        set_pend(NSRC'(1) << 10);
        skip_i = 1'b1;
        clr_mon();
        enable_ie();
        repeat (6) tick();
        check(mon_taken == 0, "R1 no entry during skip", mon_taken, 0);
        check(busy_o == 0, "R1 idle during skip", busy_o, 0);
        check(pend_o[10] == 1'b1, "R1 source still pending", pend_o[10], 1);
        skip_i = 1'b0;
        wait_load();
        check(mon_vec == 8'd11, "R1 entry after skip", mon_vec, 11);

        // R2 no entry while disabled; reset takes precedence
        set_pend(NSRC'(1) << 3);
        clr_mon();
        repeat (5) tick();
        check(mon_taken == 0, "R2 no entry while disabled", mon_taken, 0);
        reset_req_i = 1'b1; tick(); reset_req_i = 1'b0;
        repeat (3) tick();
        check(mon_taken == 0, "R2 reset waits for enable", mon_taken, 0);
        enable_ie();
        wait_load();
        check(mon_vec == 8'd0, "R2 reset vector", mon_vec, 0);
        check(mon_pc == '0, "R2 reset target", mon_pc, 0);
        check(pend_o == (NSRC'(1) << 3), "R2 hw bit untouched by reset", pend_o, NSRC'(1) << 3);
        clr_mon();
        enable_ie();
        wait_load();
        check(mon_vec == 8'd4, "R2 hw after reset", mon_vec, 4);

        // R1 skip also holds off a reset entry
        reset_req_i = 1'b1; tick(); reset_req_i = 1'b0;
        skip_i = 1'b1;
        clr_mon();
        enable_ie();
        repeat (4) tick();
        check(mon_taken == 0, "R1 reset held by skip", mon_taken, 0);
        skip_i = 1'b0;
        wait_load();
        check(mon_vec == 8'd0, "R1 reset after skip", mon_vec, 0);

        // R7 R9 R6: enable write, pointer load and new request during busy
        pc_bytes_i = 2'd3; cur_pc_i = 22'h2ABCDE;
        load_sp(16'h0300);
        set_pend(NSRC'(1) << 5);
        clr_mon();
        enable_ie();
        tick();
        check(busy_o == 1'b1, "R9 busy after acceptance", busy_o, 1);
        ie_wr_i = 1'b1; ie_wdata_i = 1'b1; sp_wr_i = 1'b1; sp_wdata_i = 16'h1234;
        pend_set_i = NSRC'(1) << 20;
        tick();
        ie_wr_i = 1'b0; sp_wr_i = 1'b0; pend_set_i = '0;
        wait_load();
        check_entry(6, 3, 1'b0, 22'h2ABCDE, 16'h0300);
        check(pend_o == (NSRC'(1) << 20), "R8 set during busy kept", pend_o, NSRC'(1) << 20);
        repeat (3) tick();
        check(mon_taken == 1, "R9 no entry until re-enabled", mon_taken, 1);
        clr_mon();
        enable_ie();
        wait_load();
        check(mon_vec == 8'd21, "R9 later entry", mon_vec, 21);

        // R8 set and clear of the same source in the acceptance cycle
        pc_bytes_i = 2'd0;
        set_pend(NSRC'(1) << 7);
        clr_mon();
        ie_wr_i = 1'b1; ie_wdata_i = 1'b1;
        tick();
        ie_wr_i = 1'b0;
        pend_set_i = NSRC'(1) << 7;
        tick();
        pend_set_i = '0;
        wait_load();
        check(mon_vec == 8'd8, "R8 entry for source 7", mon_vec, 8);
        check(pend_o == (NSRC'(1) << 7), "R8 same-cycle set wins", pend_o, NSRC'(1) << 7);
        clr_mon();
        enable_ie();
        wait_load();
        check(mon_vec == 8'd8, "R8 re-raised source taken", mon_vec, 8);
        check(pend_o == '0, "R8 drained", pend_o, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule